// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block forms the two counting chains that feed the phase detector of an integer-N synthesizer. On the feedback side, a prescaler that divides by either P or P+1 is combined with a swallow counter A and a main counter B. In each output period the first A prescaler periods use P+1 and the remaining B-A periods use P, so the total ratio is N = P*B + A. P is chosen at run time by a two-bit code. On the reference side, a separate counter divides the reference clock by a 14-bit ratio R.

Each chain runs in its own clock domain and emits a single-cycle pulse once per completed division. Settings are watched on every clock, and illegal settings are raised on error flags and discarded. A new legal setting takes effect only at the next output boundary, so the period that is in progress is never shortened or stretched.

Top module: `pss_divider`

## Requirements
- R1: With prescaler code 2'b00 (P=8), consecutive feedback pulses are spaced exactly 8*B + A VCO clocks apart, for any legal A and B.
- R2: Prescaler code 2'b01 selects P=16 and code 2'b10 selects P=32, with spacing P*B + A VCO clocks.
- R3: Prescaler code 2'b11 raises `pre_sel_err` from the VCO clock after it is sampled until a legal code returns, and the last legal modulus stays in use. A and B are still accepted independently.
- R4: A setting with B = 0 or A > B raises `swallow_err` one VCO clock later, and the last legal A and B pair stays in use.
- R5: Consecutive reference pulses are spaced exactly R reference clocks apart for any R from 4 to 16383.
- R6: An R value below 4 raises `ref_ratio_err` one reference clock later, and the last legal R stays in use.
- R7: A setting changed partway through an output period leaves that period at its old length. The following period uses the new value, on both the feedback and the reference side.
- R8: Each feedback and reference pulse is high for exactly one clock of its own domain.
- R9: While `rst` is high, all outputs are low. After release, the feedback chain starts from its defaults (P=8, A=0, B=2), so the first feedback pulse appears on the 16th VCO clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO-rate clock for the feedback chain |
| ref_clk | input | 1 | Reference clock for the reference chain |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| pre_sel | input | 2 | Prescaler code: 00 P=8, 01 P=16, 10 P=32, 11 illegal |
| swallow_a | input | 6 | Swallow count A (P+1 periods per output period) |
| main_b | input | 11 | Main count B (total prescaler periods per output period) |
| ref_ratio | input | 14 | Reference ratio R, legal from 4 to 16383 |
| fb_pulse | output | 1 | One-clock feedback pulse per N VCO clocks |
| ref_pulse | output | 1 | One-clock reference pulse per R reference clocks |
| pre_sel_err | output | 1 | Prescaler code is illegal |
| swallow_err | output | 1 | A/B pair is illegal |
| ref_ratio_err | output | 1 | R is below the legal minimum |

## Verification
The assertions depend on `rst` being held across at least one edge of each clock, and on the setting inputs changing only away from the edges of the domain that samples them. Under those conditions the smallest legal ratios bound the pulse spacing at 8 VCO clocks and 4 reference clocks. The bench meets these conditions by driving every setting and the reset on falling edges, and by keeping reset high for several cycles of both clocks. Illegal values are presented only long enough to check the flags and to measure one whole period.

// File: rtl/pss_pkg.sv
package pss_pkg;

    localparam int PRE_W  = 6;
    localparam int SWL_W  = 6;
    localparam int MAIN_W = 11;
    localparam int REF_W  = 14;

    typedef enum logic [1:0] {
        PS_DIV8  = 2'b00,
        PS_DIV16 = 2'b01,
        PS_DIV32 = 2'b10,
        PS_BAD   = 2'b11
    } psel_e;

    typedef struct packed {
        psel_e               sel;
        logic [SWL_W-1:0]    a;
        logic [MAIN_W-1:0]   b;
    } fb_cfg_t;

    function automatic logic [PRE_W-1:0] base_mod(input psel_e s);
        case (s)
            PS_DIV16: return PRE_W'(16);
            PS_DIV32: return PRE_W'(32);
            default:  return PRE_W'(8);
        endcase
    endfunction

    // reload value for a prescaler period: (P or P+1) - 1
    function automatic logic [PRE_W-1:0] period_load(input psel_e s, input logic extra);
        return base_mod(s) + {{(PRE_W-1){1'b0}}, extra} - PRE_W'(1);
    endfunction

endpackage

// File: rtl/pss_fb_divider.sv
module pss_fb_divider
    import pss_pkg::*;
#(
    parameter logic [1:0]        DEF_SEL = 2'b00,
    parameter logic [SWL_W-1:0]  DEF_A   = '0,
    parameter logic [MAIN_W-1:0] DEF_B   = MAIN_W'(2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel_in,
    input  logic [SWL_W-1:0]  a_in,
    input  logic [MAIN_W-1:0] b_in,
    output logic              pulse,
    output logic              sel_err,
    output logic              ab_err
);

    localparam fb_cfg_t DEF_CFG = '{sel: psel_e'(DEF_SEL), a: DEF_A, b: DEF_B};

    fb_cfg_t           held_q, cand, act_q;
    logic              sel_ok, ab_ok;
    logic [PRE_W-1:0]  pre_q, pre_d;
    logic [SWL_W-1:0]  a_q, a_d, a_dec;
    logic [MAIN_W-1:0] b_q, b_d;
    logic              period_end, cycle_end;

    assign sel_ok = (sel_in != 2'b11);
    assign ab_ok  = (b_in != '0) && ({{(MAIN_W-SWL_W){1'b0}}, a_in} <= b_in);

    // last legal value of each field, with the current input taking priority
    always_comb begin
        cand = held_q;
        if (sel_ok) cand.sel = psel_e'(sel_in);
        if (ab_ok) begin
            cand.a = a_in;
            cand.b = b_in;
        end
    end

    assign period_end = (pre_q == '0);
    assign cycle_end  = period_end && (b_q == MAIN_W'(1));
    assign a_dec      = (a_q != '0) ? a_q - SWL_W'(1) : '0;

    always_comb begin
        pre_d = pre_q - PRE_W'(1);
        a_d   = a_q;
        b_d   = b_q;
        if (cycle_end) begin
            pre_d = period_load(cand.sel, cand.a != '0);
            a_d   = cand.a;
            b_d   = cand.b;
        end else if (period_end) begin
            pre_d = period_load(act_q.sel, a_dec != '0);
            a_d   = a_dec;
            b_d   = b_q - MAIN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= DEF_CFG;
            act_q   <= DEF_CFG;
            pre_q   <= period_load(DEF_CFG.sel, DEF_A != '0);
            a_q     <= DEF_A;
            b_q     <= DEF_B;
            pulse   <= 1'b0;
            sel_err <= 1'b0;
            ab_err  <= 1'b0;
        end else begin
            held_q  <= cand;
            if (cycle_end) act_q <= cand;
            pre_q   <= pre_d;
            a_q     <= a_d;
            b_q     <= b_d;
            pulse   <= cycle_end;
            sel_err <= !sel_ok;
            ab_err  <= !ab_ok;
        end
    end

endmodule

// File: rtl/pss_ref_divider.sv
module pss_ref_divider #(
    parameter int             REF_W = pss_pkg::REF_W,
    parameter int             R_MIN = 4,
    parameter logic [REF_W-1:0] DEF_R = REF_W'(10)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REF_W-1:0] r_in,
    output logic             pulse,
    output logic             r_err
);

    logic [REF_W-1:0] held_q, cand, cnt_q;
    logic             r_ok, wrap;

    assign r_ok = (r_in >= REF_W'(R_MIN));
    assign cand = r_ok ? r_in : held_q;
    assign wrap = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= DEF_R;
            cnt_q  <= DEF_R - REF_W'(1);
            pulse  <= 1'b0;
            r_err  <= 1'b0;
        end else begin
            held_q <= cand;
            cnt_q  <= wrap ? cand - REF_W'(1) : cnt_q - REF_W'(1);
            pulse  <= wrap;
            r_err  <= !r_ok;
        end
    end

endmodule

// File: rtl/pss_divider.sv
module pss_divider
    import pss_pkg::*;
#(
    parameter logic [1:0]        DEF_SEL = 2'b00,
    parameter logic [SWL_W-1:0]  DEF_A   = '0,
    parameter logic [MAIN_W-1:0] DEF_B   = MAIN_W'(2),
    parameter logic [REF_W-1:0]  DEF_R   = REF_W'(10),
    parameter int                R_MIN   = 4
) (
    input  logic              vco_clk,
    input  logic              ref_clk,
    input  logic              rst,
    input  logic [1:0]        pre_sel,
    input  logic [SWL_W-1:0]  swallow_a,
    input  logic [MAIN_W-1:0] main_b,
    input  logic [REF_W-1:0]  ref_ratio,
    output logic              fb_pulse,
    output logic              ref_pulse,
    output logic              pre_sel_err,
    output logic              swallow_err,
    output logic              ref_ratio_err
);

    pss_fb_divider #(
        .DEF_SEL (DEF_SEL),
        .DEF_A   (DEF_A),
        .DEF_B   (DEF_B)
    ) u_fb (
        .clk     (vco_clk),
        .rst     (rst),
        .sel_in  (pre_sel),
        .a_in    (swallow_a),
        .b_in    (main_b),
        .pulse   (fb_pulse),
        .sel_err (pre_sel_err),
        .ab_err  (swallow_err)
    );

    pss_ref_divider #(
        .REF_W (REF_W),
        .R_MIN (R_MIN),
        .DEF_R (DEF_R)
    ) u_ref (
        .clk   (ref_clk),
        .rst   (rst),
        .r_in  (ref_ratio),
        .pulse (ref_pulse),
        .r_err (ref_ratio_err)
    );

endmodule

// File: rtl/pss_divider_chk.sv
module pss_divider_chk (
    input logic        vco_clk,
    input logic        ref_clk,
    input logic        rst,
    input logic [1:0]  pre_sel,
    input logic [10:0] main_b,
    input logic [13:0] ref_ratio,
    input logic        fb_pulse,
    input logic        ref_pulse,
    input logic        pre_sel_err,
    input logic        swallow_err,
    input logic        ref_ratio_err
);

    logic [3:0] fb_gap;
    logic       fb_seen;
    logic [2:0] ref_gap;
    logic       ref_seen;

    always_ff @(posedge vco_clk) begin
        if (rst) begin
            fb_gap  <= '0;
            fb_seen <= 1'b0;
        end else if (fb_pulse) begin
            fb_gap  <= '0;
            fb_seen <= 1'b1;
        end else if (fb_gap != 4'hF) begin
            fb_gap  <= fb_gap + 4'd1;
        end
    end

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            ref_gap  <= '0;
            ref_seen <= 1'b0;
        end else if (ref_pulse) begin
            ref_gap  <= '0;
            ref_seen <= 1'b1;
        end else if (ref_gap != 3'h7) begin
            ref_gap  <= ref_gap + 3'd1;
        end
    end

    // R8
    fb_single_pulse_chk: assert property (@(posedge vco_clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    // R8
    ref_single_pulse_chk: assert property (@(posedge ref_clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);

    // R1
    fb_min_spacing_chk: assert property (@(posedge vco_clk) disable iff (rst)
        (fb_pulse && fb_seen) |-> (fb_gap >= 4'd7));

    // R5
    ref_min_spacing_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (ref_pulse && ref_seen) |-> (ref_gap >= 3'd3));

    // R3
    sel_flag_chk: assert property (@(posedge vco_clk) disable iff (rst)
        (pre_sel == 2'b11) |=> pre_sel_err);

    // R4
    zero_main_flag_chk: assert property (@(posedge vco_clk) disable iff (rst)
        (main_b == 11'd0) |=> swallow_err);

    // R6
    ref_flag_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (ref_ratio < 14'd4) |=> ref_ratio_err);

endmodule

bind pss_divider pss_divider_chk u_chk (
    .vco_clk       (vco_clk),
    .ref_clk       (ref_clk),
    .rst           (rst),
    .pre_sel       (pre_sel),
    .main_b        (main_b),
    .ref_ratio     (ref_ratio),
    .fb_pulse      (fb_pulse),
    .ref_pulse     (ref_pulse),
    .pre_sel_err   (pre_sel_err),
    .swallow_err   (swallow_err),
    .ref_ratio_err (ref_ratio_err)
);

// File: tb/pss_divider_test.sv
`timescale 1ns/1ps
module pss_divider_test;

    logic        vco_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst     = 1'b1;
    logic [1:0]  pre_sel   = 2'b00;
    logic [5:0]  swallow_a = 6'd0;
    logic [10:0] main_b    = 11'd2;
    logic [13:0] ref_ratio = 14'd10;
    logic        fb_pulse, ref_pulse, pre_sel_err, swallow_err, ref_ratio_err;

    int checks   = 0;
    int failures = 0;

    always #4 vco_clk = ~vco_clk;
    always #5 ref_clk = ~ref_clk;

    pss_divider uut (
        .vco_clk       (vco_clk),
        .ref_clk       (ref_clk),
        .rst           (rst),
        .pre_sel       (pre_sel),
        .swallow_a     (swallow_a),
        .main_b        (main_b),
        .ref_ratio     (ref_ratio),
        .fb_pulse      (fb_pulse),
        .ref_pulse     (ref_pulse),
        .pre_sel_err   (pre_sel_err),
        .swallow_err   (swallow_err),
        .ref_ratio_err (ref_ratio_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_fb(input logic [1:0] s, input int a, input int b);
        pre_sel   = s;
        swallow_a = 6'(a);
        main_b    = 11'(b);
    endtask

    task automatic fb_interval(output int n);
        while (!fb_pulse) @(negedge vco_clk);
        n = 0;
        do begin
            @(negedge vco_clk);
            n++;
        end while (!fb_pulse);
    endtask

    task automatic ref_interval(output int n);
        while (!ref_pulse) @(negedge ref_clk);
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
        end while (!ref_pulse);
    endtask

    // apply a feedback setting, skip to the first boundary after it, measure one period
    task automatic fb_after(input logic [1:0] s, input int a, input int b, output int n);
        @(negedge vco_clk);
        set_fb(s, a, b);
        @(negedge vco_clk);
        while (!fb_pulse) @(negedge vco_clk);
        fb_interval(n);
    endtask

    task automatic ref_after(input int r, output int n);
        @(negedge ref_clk);
        ref_ratio = 14'(r);
        @(negedge ref_clk);
        while (!ref_pulse) @(negedge ref_clk);
        ref_interval(n);
    endtask

    task automatic t_reset;
        int n;
        repeat (3) @(negedge vco_clk);
        chk("R9 fb_pulse in reset", int'(fb_pulse), 0);
        chk("R9 ref_pulse in reset", int'(ref_pulse), 0);
        chk("R9 errors in reset", int'({pre_sel_err, swallow_err, ref_ratio_err}), 0);
        repeat (4) @(negedge vco_clk);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge vco_clk);
            n++;
        end while (!fb_pulse && n < 100);
        chk("R9 first pulse after reset", n, 16);
    endtask

    task automatic t_p8;
        int n;
        fb_after(2'b00, 3, 5, n);   chk("R1 P8 A3 B5", n, 43);
        fb_after(2'b00, 0, 1, n);   chk("R1 P8 A0 B1", n, 8);
        fb_after(2'b00, 4, 4, n);   chk("R1 P8 A4 B4", n, 36);
    endtask

    task automatic t_p16_p32;
        int n;
        fb_after(2'b01, 2, 7, n);   chk("R2 P16 A2 B7", n, 114);
        fb_after(2'b10, 31, 40, n); chk("R2 P32 A31 B40", n, 1311);
        fb_after(2'b10, 0, 3, n);   chk("R2 P32 A0 B3", n, 96);
    endtask

    task automatic t_pulse_width;
        while (!fb_pulse) @(negedge vco_clk);
        @(negedge vco_clk);
        chk("R8 fb pulse width", int'(fb_pulse), 0);
        while (!ref_pulse) @(negedge ref_clk);
        @(negedge ref_clk);
        chk("R8 ref pulse width", int'(ref_pulse), 0);
    endtask

    task automatic t_bad_sel;
        int n;
        fb_after(2'b01, 1, 3, n);   chk("R2 P16 A1 B3", n, 49);
        @(negedge vco_clk);
        pre_sel = 2'b11;
        repeat (2) @(negedge vco_clk);
        chk("R3 sel flag raised", int'(pre_sel_err), 1);
        fb_after(2'b11, 1, 3, n);   chk("R3 modulus kept", n, 49);
        fb_after(2'b11, 2, 3, n);   chk("R3 A/B still taken", n, 50);
        fb_after(2'b00, 2, 3, n);   chk("R3 legal code restored", n, 26);
        chk("R3 sel flag cleared", int'(pre_sel_err), 0);
    endtask

    task automatic t_bad_ab;
        int n;
        @(negedge vco_clk);
        set_fb(2'b00, 5, 3);
        repeat (2) @(negedge vco_clk);
        chk("R4 A>B flagged", int'(swallow_err), 1);
        fb_after(2'b00, 5, 3, n);   chk("R4 A>B ignored", n, 26);
        fb_after(2'b00, 0, 0, n);   chk("R4 B=0 ignored", n, 26);
        chk("R4 B=0 flagged", int'(swallow_err), 1);
        fb_after(2'b00, 3, 3, n);   chk("R4 legal pair taken", n, 27);
        chk("R4 flag cleared", int'(swallow_err), 0);
    endtask

    task automatic t_fb_boundary;
        int n;
        fb_after(2'b00, 0, 4, n);   chk("R7 fb baseline", n, 32);
        n = 0;
        repeat (5) begin
            @(negedge vco_clk);
            n++;
        end
        set_fb(2'b10, 1, 2);
        do begin
            @(negedge vco_clk);
            n++;
        end while (!fb_pulse);
        chk("R7 fb period in progress unchanged", n, 32);
        fb_interval(n);
        chk("R7 fb next period uses new setting", n, 65);
    endtask

    task automatic t_ref;
        int n;
        ref_after(4, n);     chk("R5 R=4", n, 4);
        ref_after(10, n);    chk("R5 R=10", n, 10);
        ref_after(1000, n);  chk("R5 R=1000", n, 1000);
        ref_after(7, n);     chk("R5 R=7", n, 7);
        @(negedge ref_clk);
        ref_ratio = 14'd2;
        repeat (2) @(negedge ref_clk);
        chk("R6 R=2 flagged", int'(ref_ratio_err), 1);
        ref_after(2, n);     chk("R6 R=2 ignored", n, 7);
        ref_after(0, n);     chk("R6 R=0 ignored", n, 7);
        ref_after(3, n);     chk("R6 R=3 ignored", n, 7);
        chk("R6 R=3 flagged", int'(ref_ratio_err), 1);
        ref_after(12, n);    chk("R6 legal R taken", n, 12);
        chk("R6 flag cleared", int'(ref_ratio_err), 0);
        n = 0;
        repeat (3) begin
            @(negedge ref_clk);
            n++;
        end
        ref_ratio = 14'd5;
        do begin
            @(negedge ref_clk);
            n++;
        end while (!ref_pulse);
        chk("R7 ref period in progress unchanged", n, 12);
        ref_interval(n);
        chk("R7 ref next period uses new setting", n, 5);
        ref_after(16383, n); chk("R5 R=16383", n, 16383);
    endtask

    initial begin
        repeat (190000) @(posedge vco_clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_p8();
        t_p16_p32();
        t_pulse_width();
        t_bad_sel();
        t_bad_ab();
        t_fb_boundary();
        t_ref();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule